// File: doc/BRIEF.md
# Dual-Output Masked Interrupt Controller

This block gathers 32 level-sensitive interrupt request lines and presents them to a processor as two separate request outputs: an ordinary interrupt line and a fast interrupt line. Each output has its own enable mask. Software never writes a mask directly. It sets mask bits through one address and clears them through another, so that independent drivers can claim or release lines without a read-modify-write. Software can read the raw input levels, each masked status and each mask. It can also raise or drop a software interrupt that is merged into source 0.

Access is over a plain word-indexed register port with a select, a write strobe, an index, write data and combinational read data. An error flag marks accesses the map does not accept. Several instances can be chained. A secondary controller's ordinary output is wired to input 26 of the primary controller, and software then unmasks bit 26 there to see the secondary's requests. The block does not prioritise sources, produce vectors or detect edges.

Top module: `dual_irq_ctrl`

## Requirements
- R1: A read at index 1 or index 9 returns the raw word: the 32 input levels, with bit 0 being the OR of input 0 and the software latch.
- R2: A read at index 0 returns raw AND the ordinary mask, and a read at index 8 returns raw AND the fast mask.
- R3: A write at index 2 ORs the write data into the ordinary mask, and a write at index 10 does the same for the fast mask. A read at index 2 or 10 returns that mask.
- R4: A write at index 3 clears every ordinary mask bit whose write-data bit is 1, and a write at index 11 does the same for the fast mask.
- R5: `irq_o` is high exactly when raw AND the ordinary mask is non-zero, and `fiq_o` is high exactly when raw AND the fast mask is non-zero. Both are registered: they reflect the inputs present at a clock edge and any write taken at that same edge, and they are visible just after that edge.
- R6: A write at index 4 with bit 0 set sets the software latch, and a write at index 5 with bit 0 set clears it. Writes with bit 0 at 0 leave it unchanged. A read at index 4 returns raw bit 0 in bit 0 and zeros above.
- R7: A read at index 3, 5 or 11, or at an unmapped index (6, 7, 12 to 15), returns 0 and raises `err_o` during that access. `err_o` is low when `sel_i` is low.
- R8: A write at index 0, 1, 8 or 9, or at an unmapped index, changes no state and raises `err_o`. Writes at 2, 3, 4, 5, 10 and 11 do not raise it.
- R9: Reset is synchronous and active high. It clears both masks and the software latch, and both outputs are low after reset.
- R10: When a secondary instance's `irq_o` drives input 26 and bit 26 of the ordinary mask is set, the primary's `irq_o` rises one clock edge after the secondary's `irq_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | 32 | Level-sensitive interrupt inputs |
| sel_i | input | 1 | Register access valid this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Word index of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, zero when no read |
| err_o | output | 1 | Access not accepted by the register map |
| irq_o | output | 1 | Ordinary interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A corrupted mask bit shows up at the ports at once, through the mask readback and the status readback in the same cycle. It also shows at the request output just after the next edge, provided that bit's input is active. A software latch stuck at the wrong value shows as raw bit 0 disagreeing with input 0 on the very next read at index 1, 4 or 9. A decode fault shows as a wrong error flag or non-zero data during the access itself. A write that was dropped or wrongly taken shows up at the next readback of the affected mask. In a chained pair, a missing stage of delay shows up as the primary request appearing on the wrong edge.

// File: rtl/icu_pkg.sv
package icu_pkg;
    localparam int ADDR_W      = 4;
    localparam int N_CHAN      = 2;
    localparam int CHAN_STRIDE = 8;
    localparam int CHAN_SPAN   = 4;

    localparam logic [ADDR_W-1:0] IX_SOFT_SET = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] IX_SOFT_CLR = ADDR_W'(5);

    localparam logic [1:0] OFF_STAT = 2'd0;
    localparam logic [1:0] OFF_RAW  = 2'd1;
    localparam logic [1:0] OFF_SET  = 2'd2;
    localparam logic [1:0] OFF_CLR  = 2'd3;

    typedef struct packed {
        logic rd_stat;
        logic rd_raw;
        logic rd_mask;
        logic wr_set;
        logic wr_clr;
    } chan_acc_t;

    typedef struct packed {
        logic rd;
        logic wr_set;
        logic wr_clr;
    } soft_acc_t;

    function automatic logic [ADDR_W-1:0] chan_base(input int c);
        return ADDR_W'(c * CHAN_STRIDE);
    endfunction

    function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] base);
        return (a >= base) && ({1'b0, a} < ({1'b0, base} + (ADDR_W+1)'(CHAN_SPAN)));
    endfunction
endpackage

// File: rtl/icu_regdec.sv
module icu_regdec
    import icu_pkg::*;
(
    input  logic                           sel_i,
    input  logic                           wr_i,
    input  logic [ADDR_W-1:0]              addr_i,
    output chan_acc_t [N_CHAN-1:0]         chan_acc_o,
    output soft_acc_t                      soft_acc_o,
    output logic                           err_o
);
    logic [N_CHAN-1:0] hit;
    logic [N_CHAN-1:0] bad;
    logic              soft_hit;
    logic              soft_bad;

    genvar c;
    generate
        for (c = 0; c < N_CHAN; c++) begin : g_dec
            localparam logic [ADDR_W-1:0] BASE = chan_base(c);
            logic [ADDR_W-1:0] diff;
            logic [1:0]        off;
            chan_acc_t         acc;

            assign hit[c] = in_window(addr_i, BASE);
            assign diff   = addr_i - BASE;
            assign off    = diff[1:0];

            always_comb begin
                acc = '0;
                if (sel_i && hit[c]) begin
                    acc.rd_stat = !wr_i && (off == OFF_STAT);
                    acc.rd_raw  = !wr_i && (off == OFF_RAW);
                    acc.rd_mask = !wr_i && (off == OFF_SET);
                    acc.wr_set  =  wr_i && (off == OFF_SET);
                    acc.wr_clr  =  wr_i && (off == OFF_CLR);
                end
            end

            assign bad[c] = sel_i && hit[c] &&
                            (wr_i ? ((off == OFF_STAT) || (off == OFF_RAW))
                                  : (off == OFF_CLR));
            assign chan_acc_o[c] = acc;
        end
    endgenerate

    assign soft_hit = (addr_i == IX_SOFT_SET) || (addr_i == IX_SOFT_CLR);
    assign soft_bad = sel_i && !wr_i && (addr_i == IX_SOFT_CLR);

    always_comb begin
        soft_acc_o        = '0;
        soft_acc_o.rd     = sel_i && !wr_i && (addr_i == IX_SOFT_SET);
        soft_acc_o.wr_set = sel_i &&  wr_i && (addr_i == IX_SOFT_SET);
        soft_acc_o.wr_clr = sel_i &&  wr_i && (addr_i == IX_SOFT_CLR);
    end

    assign err_o = (sel_i && !((|hit) || soft_hit)) || (|bad) || soft_bad;
endmodule

// File: rtl/icu_soft_latch.sv
module icu_soft_latch
    import icu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  soft_acc_t acc_i,
    input  logic      bit0_i,
    output logic      soft_q_o,
    output logic      soft_d_o
);
    always_comb begin
        soft_d_o = soft_q_o;
        if (acc_i.wr_set && bit0_i)
            soft_d_o = 1'b1;
        else if (acc_i.wr_clr && bit0_i)
            soft_d_o = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) soft_q_o <= 1'b0;
        else     soft_q_o <= soft_d_o;
    end

    p_soft_set_r6: assert property (@(posedge clk) disable iff (rst)
        (acc_i.wr_set && bit0_i) |=> soft_q_o);
    p_soft_clr_r6: assert property (@(posedge clk) disable iff (rst)
        (acc_i.wr_clr && bit0_i) |=> !soft_q_o);
    p_soft_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!bit0_i) |=> $stable(soft_q_o));
endmodule

// File: rtl/icu_channel.sv
module icu_channel
    import icu_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  chan_acc_t        acc_i,
    input  logic [N_SRC-1:0] wdata_i,
    input  logic [N_SRC-1:0] raw_q_i,
    input  logic [N_SRC-1:0] raw_d_i,
    output logic [N_SRC-1:0] rdata_o,
    output logic             out_o
);
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] mask_d;

    always_comb begin
        mask_d = mask_q;
        if (acc_i.wr_set)
            mask_d = mask_q | wdata_i;
        else if (acc_i.wr_clr)
            mask_d = mask_q & ~wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            out_o  <= 1'b0;
        end else begin
            mask_q <= mask_d;
            out_o  <= |(raw_d_i & mask_d);
        end
    end

    always_comb begin
        rdata_o = '0;
        if (acc_i.rd_stat) rdata_o = raw_q_i & mask_q;
        if (acc_i.rd_raw)  rdata_o = raw_q_i;
        if (acc_i.rd_mask) rdata_o = mask_q;
    end

    p_set_ors_r3: assert property (@(posedge clk) disable iff (rst)
        acc_i.wr_set |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
    p_clr_ands_r4: assert property (@(posedge clk) disable iff (rst)
        acc_i.wr_clr |=> ((mask_q & $past(wdata_i)) == '0));
    p_mask_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(acc_i.wr_set || acc_i.wr_clr) |=> $stable(mask_q));
    p_out_needs_mask_r5: assert property (@(posedge clk) disable iff (rst)
        out_o |-> (mask_q != '0));
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
    import icu_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [N_SRC-1:0]  wdata_i,
    output logic [N_SRC-1:0]  rdata_o,
    output logic              err_o,
    output logic              irq_o,
    output logic              fiq_o
);
    localparam int IRQ_CH = 0;
    localparam int FIQ_CH = 1;

    chan_acc_t [N_CHAN-1:0] chan_acc;
    soft_acc_t              soft_acc;
    logic                   soft_q;
    logic                   soft_d;
    logic [N_SRC-1:0]       raw_q;
    logic [N_SRC-1:0]       raw_d;
    logic [N_SRC-1:0]       chan_rd [N_CHAN];
    logic [N_CHAN-1:0]      chan_out;

    icu_regdec u_dec (
        .sel_i      (sel_i),
        .wr_i       (wr_i),
        .addr_i     (addr_i),
        .chan_acc_o (chan_acc),
        .soft_acc_o (soft_acc),
        .err_o      (err_o)
    );

    icu_soft_latch u_soft (
        .clk      (clk),
        .rst      (rst),
        .acc_i    (soft_acc),
        .bit0_i   (wdata_i[0]),
        .soft_q_o (soft_q),
        .soft_d_o (soft_d)
    );

    assign raw_q = src_i | N_SRC'(soft_q);
    assign raw_d = src_i | N_SRC'(soft_d);

    genvar c;
    generate
        for (c = 0; c < N_CHAN; c++) begin : g_chan
            icu_channel #(.N_SRC(N_SRC)) u_chan (
                .clk     (clk),
                .rst     (rst),
                .acc_i   (chan_acc[c]),
                .wdata_i (wdata_i),
                .raw_q_i (raw_q),
                .raw_d_i (raw_d),
                .rdata_o (chan_rd[c]),
                .out_o   (chan_out[c])
            );
        end
    endgenerate

    always_comb begin
        rdata_o = soft_acc.rd ? N_SRC'(raw_q[0]) : '0;
        for (int k = 0; k < N_CHAN; k++)
            rdata_o = rdata_o | chan_rd[k];
    end

    assign irq_o = chan_out[IRQ_CH];
    assign fiq_o = chan_out[FIQ_CH];

    p_reset_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!irq_o && !fiq_o));
    p_bad_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (sel_i && !wr_i && err_o) |-> (rdata_o == '0));
    p_idle_no_err_r7: assert property (@(posedge clk) disable iff (rst)
        !sel_i |-> (!err_o && rdata_o == '0));
    p_bad_write_soft_r8: assert property (@(posedge clk) disable iff (rst)
        (sel_i && wr_i && err_o) |=> $stable(soft_q));
endmodule

// File: tb/dual_irq_ctrl_test.sv
`timescale 1ns/1ps
module dual_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        b_sel  [2];
    logic        b_wr   [2];
    logic [3:0]  b_addr [2];
    logic [31:0] b_wd   [2];
    logic [31:0] src    [2];
    logic [31:0] rd     [2];
    logic        er     [2];
    logic        irqo   [2];
    logic        fiqo   [2];

    // bench model
    logic [31:0] mi [2];
    logic [31:0] mf [2];
    logic        ms [2];
    logic        exp_irq [2];
    logic        exp_fiq [2];

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    dual_irq_ctrl uut (
        .clk(clk), .rst(rst),
        .src_i({src[0][31:27], irqo[1], src[0][25:0]}),
        .sel_i(b_sel[0]), .wr_i(b_wr[0]), .addr_i(b_addr[0]), .wdata_i(b_wd[0]),
        .rdata_o(rd[0]), .err_o(er[0]), .irq_o(irqo[0]), .fiq_o(fiqo[0])
    );

    dual_irq_ctrl u_second (
        .clk(clk), .rst(rst), .src_i(src[1]),
        .sel_i(b_sel[1]), .wr_i(b_wr[1]), .addr_i(b_addr[1]), .wdata_i(b_wd[1]),
        .rdata_o(rd[1]), .err_o(er[1]), .irq_o(irqo[1]), .fiq_o(fiqo[1])
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
        end
    endtask

    // read model: {err, data}
    function automatic logic [32:0] rd_model(input logic [3:0] a, input logic [31:0] raw,
                                             input logic [31:0] im, input logic [31:0] fm);
        case (a)
            4'd0:        return {1'b0, raw & im};
            4'd1, 4'd9:  return {1'b0, raw};
            4'd2:        return {1'b0, im};
            4'd4:        return {1'b0, 31'b0, raw[0]};
            4'd8:        return {1'b0, raw & fm};
            4'd10:       return {1'b0, fm};
            default:     return {1'b1, 32'b0};
        endcase
    endfunction

    function automatic string rd_tag(input logic [3:0] a);
        case (a)
            4'd0, 4'd8:  return "R2";
            4'd1, 4'd9:  return "R1";
            4'd2, 4'd10: return "R3";
            4'd4:        return "R6";
            default:     return "R7";
        endcase
    endfunction

    function automatic logic wr_bad(input logic [3:0] a);
        return !(a inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd10, 4'd11});
    endfunction

    function automatic logic [31:0] esrc(input int k);
        if (k == 0) return {src[0][31:27], exp_irq[1], src[0][25:0]};
        return src[1];
    endfunction

    // one clock: check combinational read, advance model, check outputs after edge
    task automatic tick(input string tag_ovr = "");
        logic [31:0] nmi [2];
        logic [31:0] nmf [2];
        logic        nms [2];
        logic        nirq [2];
        logic        nfiq [2];
        #1;
        for (int k = 0; k < 2; k++) begin
            logic [31:0] e;
            logic [31:0] raw;
            logic [32:0] m;
            string       t;
            e   = esrc(k);
            raw = e | {31'b0, ms[k]};
            if (b_sel[k] && !b_wr[k]) begin
                m = rd_model(b_addr[k], raw, mi[k], mf[k]);
                t = (tag_ovr != "") ? tag_ovr : rd_tag(b_addr[k]);
                chk(rd[k] == m[31:0], t, rd[k], m[31:0]);
                chk(er[k] == m[32], "R7", {31'b0, er[k]}, {31'b0, m[32]});
            end else if (b_sel[k]) begin
                chk(er[k] == wr_bad(b_addr[k]), "R8", {31'b0, er[k]}, {31'b0, wr_bad(b_addr[k])});
            end else begin
                chk(er[k] == 1'b0, "R7", {31'b0, er[k]}, 32'b0);
            end
            nmi[k] = mi[k];
            nmf[k] = mf[k];
            nms[k] = ms[k];
            if (b_sel[k] && b_wr[k]) begin
                case (b_addr[k])
                    4'd2:  nmi[k] = mi[k] | b_wd[k];
                    4'd3:  nmi[k] = mi[k] & ~b_wd[k];
                    4'd10: nmf[k] = mf[k] | b_wd[k];
                    4'd11: nmf[k] = mf[k] & ~b_wd[k];
                    4'd4:  if (b_wd[k][0]) nms[k] = 1'b1;
                    4'd5:  if (b_wd[k][0]) nms[k] = 1'b0;
                    default: ;
                endcase
            end
            nirq[k] = |((e | {31'b0, nms[k]}) & nmi[k]);
            nfiq[k] = |((e | {31'b0, nms[k]}) & nmf[k]);
        end
        @(posedge clk);
        for (int k = 0; k < 2; k++) begin
            mi[k] = nmi[k]; mf[k] = nmf[k]; ms[k] = nms[k];
            exp_irq[k] = nirq[k]; exp_fiq[k] = nfiq[k];
        end
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk(irqo[k] == exp_irq[k], "R5", {31'b0, irqo[k]}, {31'b0, exp_irq[k]});
            chk(fiqo[k] == exp_fiq[k], "R5", {31'b0, fiqo[k]}, {31'b0, exp_fiq[k]});
            b_sel[k] = 1'b0;
            b_wr[k]  = 1'b0;
        end
    endtask

    task automatic wr(input int k, input logic [3:0] a, input logic [31:0] d);
        b_sel[k] = 1'b1; b_wr[k] = 1'b1; b_addr[k] = a; b_wd[k] = d;
        tick();
    endtask

    task automatic rdr(input int k, input logic [3:0] a, input string tag = "");
        b_sel[k] = 1'b1; b_wr[k] = 1'b0; b_addr[k] = a; b_wd[k] = $urandom;
        tick(tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int k = 0; k < 2; k++) begin
            b_sel[k] = 0; b_wr[k] = 0; b_addr[k] = 0; b_wd[k] = 0; src[k] = 0;
            mi[k] = 0; mf[k] = 0; ms[k] = 0; exp_irq[k] = 0; exp_fiq[k] = 0;
        end
        // R9: reset with active inputs and access attempts
        src[0] = 32'hFFFF_FFFF;
        b_sel[0] = 1'b1; b_wr[0] = 1'b1; b_addr[0] = 4'd2; b_wd[0] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        chk(irqo[0] == 1'b0, "R9", {31'b0, irqo[0]}, 32'b0);
        chk(fiqo[0] == 1'b0, "R9", {31'b0, fiqo[0]}, 32'b0);
        b_sel[0] = 1'b0; b_wr[0] = 1'b0;
        rst = 1'b0;
        src[0] = 32'h0;
        rdr(0, 4'd2, "R9");
        rdr(0, 4'd10, "R9");
        rdr(0, 4'd4, "R9");

        // R1 / R2 / R3 / R5
        src[0] = 32'h0000_0FF0;
        rdr(0, 4'd1);
        rdr(0, 4'd0);
        wr(0, 4'd2, 32'hFFFF_0F0F);
        rdr(0, 4'd2);
        rdr(0, 4'd0);
        // R4
        wr(0, 4'd3, 32'h0000_0F00);
        rdr(0, 4'd2, "R4");
        wr(0, 4'd10, 32'h0000_0010);
        rdr(0, 4'd8);
        rdr(0, 4'd9);
        wr(0, 4'd11, 32'hFFFF_FFFF);
        rdr(0, 4'd10, "R4");

        // R6: software latch
        src[0] = 32'h0;
        wr(0, 4'd4, 32'hFFFF_FFFE);
        rdr(0, 4'd4, "R6");
        wr(0, 4'd4, 32'h0000_0001);
        rdr(0, 4'd4, "R6");
        rdr(0, 4'd1, "R6");
        wr(0, 4'd2, 32'h0000_0001);
        wr(0, 4'd5, 32'hFFFF_FFFE);
        rdr(0, 4'd4, "R6");
        wr(0, 4'd5, 32'h0000_0001);
        rdr(0, 4'd4, "R6");
        src[0] = 32'h0000_0001;
        rdr(0, 4'd4, "R6");
        src[0] = 32'h0;

        // R7: clear-only and unmapped reads
        rdr(0, 4'd3);
        rdr(0, 4'd5);
        rdr(0, 4'd11);
        rdr(0, 4'd6);
        rdr(0, 4'd15);

        // R8: writes to read-only and unmapped indices
        wr(0, 4'd0, 32'hFFFF_FFFF);
        wr(0, 4'd1, 32'hFFFF_FFFF);
        wr(0, 4'd8, 32'hFFFF_FFFF);
        wr(0, 4'd9, 32'hFFFF_FFFF);
        wr(0, 4'd7, 32'hFFFF_FFFF);
        rdr(0, 4'd2, "R8");
        rdr(0, 4'd10, "R8");
        rdr(0, 4'd4, "R8");

        // R10: cascade through input 26
        wr(0, 4'd3, 32'hFFFF_FFFF);
        wr(0, 4'd11, 32'hFFFF_FFFF);
        wr(0, 4'd2, 32'h0400_0000);
        wr(1, 4'd2, 32'h0000_0020);
        src[1] = 32'h0000_0020;
        tick();
        chk(irqo[1] == 1'b1, "R10", {31'b0, irqo[1]}, 32'h1);
        chk(irqo[0] == 1'b0, "R10", {31'b0, irqo[0]}, 32'h0);
        tick();
        chk(irqo[0] == 1'b1, "R10", {31'b0, irqo[0]}, 32'h1);
        rdr(0, 4'd0, "R10");
        src[1] = 32'h0;
        tick();
        tick();
        chk(irqo[0] == 1'b0, "R10", {31'b0, irqo[0]}, 32'h0);

        // random mix on both instances
        for (int i = 0; i < 1500; i++) begin
            for (int k = 0; k < 2; k++) begin
                int unsigned r;
                r = $urandom % 8;
                if (r < 5) begin
                    b_sel[k]  = 1'b1;
                    b_wr[k]   = $urandom % 2;
                    b_addr[k] = 4'($urandom % 16);
                    case ($urandom % 4)
                        0:       b_wd[k] = 32'h1 << ($urandom % 32);
                        1:       b_wd[k] = 32'hFFFF_FFFF;
                        default: b_wd[k] = $urandom;
                    endcase
                end
                if ($urandom % 4 == 0)
                    src[k] = $urandom & $urandom;
            end
            tick();
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule